// File: doc/BRIEF.md
# Time-Scheduled State Mailbox

This block is a one-way store for state values passed from a producer to a consumer. Each of its entries keeps the latest full value, the global time at which that value was written (the observation stamp) and a valid bit. A new write replaces the entry in place. A read leaves the entry as it was, so the consumer may sample the same value as often as it likes. No signal goes back from the consumer to the producer.

A global-time input drives a fixed schedule. Within each round of the low time bits, every entry has its own fetch instant, at which the communication side takes a copy of the entry. Both sides know this schedule in advance. A producer write that lands on an entry in the cycle of that entry's fetch is held back for one cycle, so the fetch sees a consistent old value, and the block raises a conflict pulse. Each value read or fetched is also marked stale when its age on the global time base exceeds a programmable accuracy limit.

Top module: `state_mailbox`

## Requirements
- R1: While reset is asserted and right after it, every entry is invalid, rd_valid, fetch_valid and conflict are 0, and rd_stale is 1.
- R2: A write stores wr_data and the gtime of its cycle as the stamp, and sets the entry valid. A read issued with rd_en in cycle n presents rd_data, rd_stamp and rd_valid of entry rd_idx after the clock edge that ends cycle n.
- R3: A later write to an entry replaces the earlier value completely. Only the latest value can be read.
- R4: Reads do not consume data. Repeated reads of an entry with no write in between return the same value.
- R5: With the defaults (5-bit round, offset 1, stride 4), entry e is fetched when gtime[4:0] equals 1 + 4*e. After the edge that ends that cycle, fetch_valid is 1 for one cycle, and fetch_idx, fetch_data and fetch_stamp show the entry as it stood before that edge. At all other times fetch_valid is 0.
- R6: A write to the entry being fetched in the same cycle does not change what the fetch returns. conflict is 1 in the next cycle, and the held value, with the stamp of its original cycle, becomes readable one cycle later than an unheld write.
- R7: rd_stale (and fetch_stale) is 1 when the entry is invalid, or when (gtime - stamp) modulo 2^TIME_W, taken in the read (fetch) cycle, is greater than acc_limit. An age equal to the limit is not stale.
- R8: A read in the same cycle as a write to the same entry returns the value from before that write.
- R9: When a held write and a new direct write target the same entry in the same cycle, the direct write wins.
- R10: Age is computed modulo 2^TIME_W, so a stamp taken just before gtime wraps gives the correct small age after the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gtime | input | TIME_W | Global time base |
| acc_limit | input | TIME_W | Largest age still counted as accurate |
| wr_en | input | 1 | Producer write strobe |
| wr_idx | input | IDX_W | Producer entry index |
| wr_data | input | DATA_W | Producer state value |
| rd_en | input | 1 | Consumer read strobe |
| rd_idx | input | IDX_W | Consumer entry index |
| rd_data | output | DATA_W | Value read, one cycle after rd_en |
| rd_stamp | output | TIME_W | Observation stamp of the value read |
| rd_valid | output | 1 | Entry read has been written since reset |
| rd_stale | output | 1 | Value read is invalid or too old |
| fetch_valid | output | 1 | One-cycle pulse after a scheduled fetch |
| fetch_idx | output | IDX_W | Entry taken by the last fetch |
| fetch_data | output | DATA_W | Value taken by the last fetch |
| fetch_stamp | output | TIME_W | Stamp of the value taken by the last fetch |
| fetch_stale | output | 1 | Fetched value was invalid or too old |
| conflict | output | 1 | A write hit its entry's fetch instant in the previous cycle |

## Verification
The main function is tried with a write-then-read stream that walks through several entries, with writes placed on and just off the fetch instants. This separates a held write from a direct one and shows whether a fetch returns the old value. Back-to-back writes to one entry around a conflict show which of the held and the direct write wins. Read-in-write-cycle patterns separate read-old from write-through behaviour. Time jumps that put the age exactly at the limit, one past it, and across the wrap of gtime separate a strict comparison from an inclusive one and modular age from plain subtraction.

// File: rtl/smb_pkg.sv
package smb_pkg;

   // how an age equal to the limit is judged
   typedef enum logic {
      STALE_STRICT    = 1'b0,   // stale only when age > limit
      STALE_INCLUSIVE = 1'b1    // stale when age >= limit
   } stale_rule_e;

   localparam int DEF_DATA_W = 16;
   localparam int DEF_TIME_W = 16;
   localparam int DEF_DEPTH  = 8;

endpackage

// File: rtl/smb_schedule.sv
// Static fetch schedule: entry e owns phase SLOT_OFFSET + e*SLOT_STRIDE.
module smb_schedule #(
   parameter int DEPTH       = 8,
   parameter int IDX_W       = 3,
   parameter int ROUND_W     = 5,
   parameter int SLOT_OFFSET = 1,
   parameter int SLOT_STRIDE = 4
) (
   input  logic [ROUND_W-1:0] phase,
   output logic               hit,
   output logic [IDX_W-1:0]   idx
);

   logic [DEPTH-1:0] match;

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      localparam int SLOT_AT = SLOT_OFFSET + e * SLOT_STRIDE;
      assign match[e] = (phase == ROUND_W'(SLOT_AT));
   end

   always_comb begin
      idx = '0;
      for (int e = 0; e < DEPTH; e++) begin
         if (match[e]) idx = IDX_W'(e);
      end
   end

   assign hit = |match;

endmodule

// File: rtl/smb_age.sv
// Temporal accuracy test of one stamped value.
module smb_age #(
   parameter int                  TIME_W = 16,
   parameter smb_pkg::stale_rule_e RULE  = smb_pkg::STALE_STRICT
) (
   input  logic [TIME_W-1:0] now,
   input  logic [TIME_W-1:0] stamp,
   input  logic              valid,
   input  logic [TIME_W-1:0] limit,
   output logic              stale
);

   logic [TIME_W-1:0] age;
   logic              too_old;

   assign age = now - stamp;   // modular on purpose: survives time wrap

   if (RULE == smb_pkg::STALE_INCLUSIVE) begin : g_incl
      assign too_old = (age >= limit);
   end else begin : g_strict
      assign too_old = (age > limit);
   end

   assign stale = !valid || too_old;

endmodule

// File: rtl/smb_store.sv
// Entry storage: two write ports (B has priority), two read ports.
module smb_store #(
   parameter int DEPTH  = 8,
   parameter int IDX_W  = 3,
   parameter int DATA_W = 16,
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_we,
   input  logic [IDX_W-1:0]  a_idx,
   input  logic [DATA_W-1:0] a_data,
   input  logic [TIME_W-1:0] a_stamp,
   input  logic              b_we,
   input  logic [IDX_W-1:0]  b_idx,
   input  logic [DATA_W-1:0] b_data,
   input  logic [TIME_W-1:0] b_stamp,
   input  logic [IDX_W-1:0]  r_idx,
   output logic [DATA_W-1:0] r_data,
   output logic [TIME_W-1:0] r_stamp,
   output logic              r_valid,
   input  logic [IDX_W-1:0]  f_idx,
   output logic [DATA_W-1:0] f_data,
   output logic [TIME_W-1:0] f_stamp,
   output logic              f_valid
);

   logic [DATA_W-1:0] data_q  [DEPTH];
   logic [TIME_W-1:0] stamp_q [DEPTH];
   logic [DEPTH-1:0]  valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) begin
            data_q[e]  <= '0;
            stamp_q[e] <= '0;
         end
         valid_q <= '0;
      end else begin
         for (int e = 0; e < DEPTH; e++) begin
            if (b_we && b_idx == IDX_W'(e)) begin
               data_q[e]  <= b_data;
               stamp_q[e] <= b_stamp;
               valid_q[e] <= 1'b1;
            end else if (a_we && a_idx == IDX_W'(e)) begin
               data_q[e]  <= a_data;
               stamp_q[e] <= a_stamp;
               valid_q[e] <= 1'b1;
            end
         end
      end
   end

   assign r_data  = data_q[r_idx];
   assign r_stamp = stamp_q[r_idx];
   assign r_valid = valid_q[r_idx];
   assign f_data  = data_q[f_idx];
   assign f_stamp = stamp_q[f_idx];
   assign f_valid = valid_q[f_idx];

endmodule

// File: rtl/state_mailbox.sv
module state_mailbox #(
   parameter int                   DATA_W      = smb_pkg::DEF_DATA_W,
   parameter int                   TIME_W      = smb_pkg::DEF_TIME_W,
   parameter int                   DEPTH       = smb_pkg::DEF_DEPTH,
   parameter int                   ROUND_W     = 5,
   parameter int                   SLOT_OFFSET = 1,
   parameter int                   SLOT_STRIDE = 4,
   parameter smb_pkg::stale_rule_e STALE_RULE  = smb_pkg::STALE_STRICT,
   localparam int                  IDX_W       = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] gtime,
   input  logic [TIME_W-1:0] acc_limit,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic [TIME_W-1:0] rd_stamp,
   output logic              rd_valid,
   output logic              rd_stale,
   output logic              fetch_valid,
   output logic [IDX_W-1:0]  fetch_idx,
   output logic [DATA_W-1:0] fetch_data,
   output logic [TIME_W-1:0] fetch_stamp,
   output logic              fetch_stale,
   output logic              conflict
);

   localparam int LAST_SLOT = SLOT_OFFSET + (DEPTH - 1) * SLOT_STRIDE;

   // elaboration-time parameter checks
   if (DEPTH < 2) begin : g_bad_depth
      $error("state_mailbox: DEPTH must be at least 2");
   end
   if (SLOT_STRIDE < 2) begin : g_bad_stride
      $error("state_mailbox: SLOT_STRIDE must be at least 2");
   end
   if (LAST_SLOT >= (1 << ROUND_W)) begin : g_bad_round
      $error("state_mailbox: schedule does not fit in one round");
   end
   if (ROUND_W > TIME_W) begin : g_bad_time
      $error("state_mailbox: ROUND_W exceeds TIME_W");
   end

   // schedule decode
   logic             slot_hit;
   logic [IDX_W-1:0] slot_idx;

   smb_schedule #(
      .DEPTH(DEPTH), .IDX_W(IDX_W), .ROUND_W(ROUND_W),
      .SLOT_OFFSET(SLOT_OFFSET), .SLOT_STRIDE(SLOT_STRIDE)
   ) u_sched (
      .phase(gtime[ROUND_W-1:0]),
      .hit  (slot_hit),
      .idx  (slot_idx)
   );

   // write steering: a write on its entry's fetch instant is held one cycle
   logic              clash;
   logic              direct_we;
   logic              hold_v;
   logic [IDX_W-1:0]  hold_idx;
   logic [DATA_W-1:0] hold_data;
   logic [TIME_W-1:0] hold_stamp;

   assign clash     = wr_en && slot_hit && (wr_idx == slot_idx);
   assign direct_we = wr_en && !clash;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v     <= 1'b0;
         hold_idx   <= '0;
         hold_data  <= '0;
         hold_stamp <= '0;
      end else begin
         hold_v <= clash;
         if (clash) begin
            hold_idx   <= wr_idx;
            hold_data  <= wr_data;
            hold_stamp <= gtime;
         end
      end
   end

   assign conflict = hold_v;

   // storage
   logic [DATA_W-1:0] rd_data_c, ft_data_c;
   logic [TIME_W-1:0] rd_stamp_c, ft_stamp_c;
   logic              rd_valid_c, ft_valid_c;

   smb_store #(
      .DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W), .TIME_W(TIME_W)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_we   (hold_v),
      .a_idx  (hold_idx),
      .a_data (hold_data),
      .a_stamp(hold_stamp),
      .b_we   (direct_we),
      .b_idx  (wr_idx),
      .b_data (wr_data),
      .b_stamp(gtime),
      .r_idx  (rd_idx),
      .r_data (rd_data_c),
      .r_stamp(rd_stamp_c),
      .r_valid(rd_valid_c),
      .f_idx  (slot_idx),
      .f_data (ft_data_c),
      .f_stamp(ft_stamp_c),
      .f_valid(ft_valid_c)
   );

   // accuracy tests for both paths
   logic rd_stale_c, ft_stale_c;

   smb_age #(.TIME_W(TIME_W), .RULE(STALE_RULE)) u_age_rd (
      .now(gtime), .stamp(rd_stamp_c), .valid(rd_valid_c),
      .limit(acc_limit), .stale(rd_stale_c)
   );

   smb_age #(.TIME_W(TIME_W), .RULE(STALE_RULE)) u_age_ft (
      .now(gtime), .stamp(ft_stamp_c), .valid(ft_valid_c),
      .limit(acc_limit), .stale(ft_stale_c)
   );

   // consumer read port, one cycle latency
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_stamp <= '0;
         rd_valid <= 1'b0;
         rd_stale <= 1'b1;
      end else if (rd_en) begin
         rd_data  <= rd_data_c;
         rd_stamp <= rd_stamp_c;
         rd_valid <= rd_valid_c;
         rd_stale <= rd_stale_c;
      end
   end

   // communication-side fetch register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetch_valid <= 1'b0;
         fetch_idx   <= '0;
         fetch_data  <= '0;
         fetch_stamp <= '0;
         fetch_stale <= 1'b0;
      end else begin
         fetch_valid <= slot_hit;
         if (slot_hit) begin
            fetch_idx   <= slot_idx;
            fetch_data  <= ft_data_c;
            fetch_stamp <= ft_stamp_c;
            fetch_stale <= ft_stale_c;
         end
      end
   end

endmodule

// File: rtl/smb_checker.sv
module smb_checker #(
   parameter int DATA_W      = 16,
   parameter int IDX_W       = 3,
   parameter int ROUND_W     = 5,
   parameter int SLOT_OFFSET = 1,
   parameter int SLOT_STRIDE = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ROUND_W-1:0] phase,
   input logic               wr_en,
   input logic [IDX_W-1:0]   wr_idx,
   input logic               rd_en,
   input logic [IDX_W-1:0]   rd_idx,
   input logic [DATA_W-1:0]  rd_data,
   input logic               rd_valid,
   input logic               rd_stale,
   input logic               fetch_valid,
   input logic [IDX_W-1:0]   fetch_idx,
   input logic               conflict
);

   // cycles since reset, saturating: keeps $past inside the running window
   logic [1:0] up_cnt;
   logic       armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               up_cnt <= '0;
      else if (up_cnt != 2'd3)  up_cnt <= up_cnt + 2'd1;
   end
   assign armed = (up_cnt == 2'd3);

   logic [ROUND_W-1:0] slot_of_fetch;
   assign slot_of_fetch = ROUND_W'(SLOT_OFFSET) + ROUND_W'(fetch_idx) * ROUND_W'(SLOT_STRIDE);

   // R5: a fetch pulse follows the fetched entry's own phase
   p_fetch_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      armed && fetch_valid |-> $past(phase) == slot_of_fetch);

   // R5: fetch pulses never last two cycles
   p_fetch_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |=> !fetch_valid);

   // R6: a conflict is a write to the entry fetched in the same cycle
   p_conflict_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      armed && conflict |-> $past(wr_en) && $past(wr_idx) == fetch_idx && fetch_valid);

   // R7: an unwritten entry always reads as stale
   p_invalid_stale_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> rd_stale);

   // R4: repeated reads with no write in between return the same value
   p_read_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      armed && rd_en && $past(rd_en) && rd_idx == $past(rd_idx)
      && !$past(wr_en) && !$past(conflict) |=> $stable(rd_data));

endmodule

bind state_mailbox smb_checker #(
   .DATA_W(DATA_W), .IDX_W(IDX_W), .ROUND_W(ROUND_W),
   .SLOT_OFFSET(SLOT_OFFSET), .SLOT_STRIDE(SLOT_STRIDE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .phase(gtime[ROUND_W-1:0]),
   .wr_en(wr_en), .wr_idx(wr_idx), .rd_en(rd_en), .rd_idx(rd_idx),
   .rd_data(rd_data), .rd_valid(rd_valid), .rd_stale(rd_stale),
   .fetch_valid(fetch_valid), .fetch_idx(fetch_idx), .conflict(conflict)
);

// File: tb/state_mailbox_tb_top.sv
module state_mailbox_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] gtime = '0;
   logic [15:0] acc_limit = 16'd20;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic [15:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [2:0]  rd_idx = '0;
   logic [15:0] rd_data, rd_stamp, fetch_data, fetch_stamp;
   logic        rd_valid, rd_stale, fetch_valid, fetch_stale, conflict;
   logic [2:0]  fetch_idx;

   always #10 clk = ~clk;   // 50 MHz

   state_mailbox dut_i (
      .clk(clk), .rst_n(rst_n), .gtime(gtime), .acc_limit(acc_limit),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_en(rd_en), .rd_idx(rd_idx),
      .rd_data(rd_data), .rd_stamp(rd_stamp), .rd_valid(rd_valid), .rd_stale(rd_stale),
      .fetch_valid(fetch_valid), .fetch_idx(fetch_idx), .fetch_data(fetch_data),
      .fetch_stamp(fetch_stamp), .fetch_stale(fetch_stale), .conflict(conflict)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;
   logic [15:0] tnow = '0;

   // bench-side expectation state, built from the requirements
   logic [15:0] m_data  [8];
   logic [15:0] m_stamp [8];
   logic        m_valid [8];
   logic        m_hv;
   logic [2:0]  m_hidx;
   logic [15:0] m_hdata, m_hstamp;

   task automatic model_clear();
      for (int e = 0; e < 8; e++) begin
         m_data[e] = '0; m_stamp[e] = '0; m_valid[e] = 1'b0;
      end
      m_hv = 1'b0; m_hidx = '0; m_hdata = '0; m_hstamp = '0;
   endtask

   function automatic logic exp_stale(input logic v, input logic [15:0] st, input logic [15:0] t);
      logic [15:0] age;
      age = t - st;
      return !v || (age > acc_limit);
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // one cycle: drive, sample after the edge, compare, advance the model
   task automatic step(input logic we, input logic [2:0] wi, input logic [15:0] wd,
                       input logic re, input logic [2:0] ri);
      logic        hit, clash;
      logic [2:0]  fe;
      logic [15:0] e_rd, e_rs, e_fd, e_fs;
      logic        e_rv, e_rst, e_fst, e_fv;
      wr_en = we; wr_idx = wi; wr_data = wd; rd_en = re; rd_idx = ri; gtime = tnow;
      hit   = (tnow[1:0] == 2'd1);          // phase 1 + 4*e within a 32-step round
      fe    = tnow[4:2];
      clash = we && hit && (wi == fe);
      e_rd  = m_data[ri]; e_rs = m_stamp[ri]; e_rv = m_valid[ri];
      e_rst = exp_stale(m_valid[ri], m_stamp[ri], tnow);
      e_fd  = m_data[fe]; e_fs = m_stamp[fe]; e_fv = m_valid[fe];
      e_fst = exp_stale(e_fv, e_fs, tnow);
      @(posedge clk);
      #2;
      if (re) begin
         check(rd_data == e_rd,   "R2 rd_data",  32'(rd_data),  32'(e_rd));
         check(rd_stamp == e_rs,  "R2 rd_stamp", 32'(rd_stamp), 32'(e_rs));
         check(rd_valid == e_rv,  "R2 rd_valid", 32'(rd_valid), 32'(e_rv));
         check(rd_stale == e_rst, "R7 rd_stale", 32'(rd_stale), 32'(e_rst));
      end
      check(fetch_valid == hit, "R5 fetch_valid", 32'(fetch_valid), 32'(hit));
      if (hit) begin
         check(fetch_idx == fe && fetch_data == e_fd && fetch_stamp == e_fs,
               "R5 fetch entry", {fetch_idx, 13'd0, fetch_data}, {fe, 13'd0, e_fd});
         check(fetch_stale == e_fst, "R7 fetch_stale", 32'(fetch_stale), 32'(e_fst));
      end
      check(conflict == clash, "R6 conflict", 32'(conflict), 32'(clash));
      // held write lands first, a direct write to the same entry overrides it (R9)
      if (m_hv) begin
         m_data[m_hidx] = m_hdata; m_stamp[m_hidx] = m_hstamp; m_valid[m_hidx] = 1'b1;
      end
      m_hv = clash;
      if (clash) begin
         m_hidx = wi; m_hdata = wd; m_hstamp = tnow;
      end else if (we) begin
         m_data[wi] = wd; m_stamp[wi] = tnow; m_valid[wi] = 1'b1;
      end
      tnow = tnow + 16'd1;
   endtask

   // {wr_en, wr_idx, wr_data, rd_en, rd_idx}; row k runs at gtime 2+k
   localparam logic [23:0] VEC [16] = '{
      {1'b1, 3'd0, 16'hA000, 1'b0, 3'd0},   // t2  plain write (R2)
      {1'b1, 3'd1, 16'hA001, 1'b1, 3'd0},   // t3  read back entry 0 (R2)
      {1'b1, 3'd2, 16'hA002, 1'b1, 3'd1},   // t4
      {1'b1, 3'd1, 16'hB001, 1'b1, 3'd1},   // t5  write on fetch of entry 1 (R6)
      {1'b0, 3'd0, 16'h0000, 1'b1, 3'd1},   // t6  held value not yet visible (R6)
      {1'b0, 3'd0, 16'h0000, 1'b1, 3'd1},   // t7  held value now visible (R3, R6)
      {1'b1, 3'd3, 16'hA003, 1'b1, 3'd2},   // t8
      {1'b1, 3'd3, 16'hB003, 1'b1, 3'd3},   // t9  read during write (R8)
      {1'b0, 3'd0, 16'h0000, 1'b1, 3'd3},   // t10 overwrite seen (R3)
      {1'b1, 3'd7, 16'h7777, 1'b1, 3'd7},   // t11 read of unwritten entry (R7)
      {1'b0, 3'd0, 16'h0000, 1'b1, 3'd7},   // t12
      {1'b1, 3'd3, 16'hC003, 1'b0, 3'd0},   // t13 conflict on entry 3 (R6)
      {1'b1, 3'd3, 16'hD003, 1'b1, 3'd3},   // t14 direct write beats held one (R9)
      {1'b0, 3'd0, 16'h0000, 1'b1, 3'd3},   // t15
      {1'b0, 3'd0, 16'h0000, 1'b1, 3'd3},   // t16 repeat read (R4)
      {1'b1, 3'd4, 16'h4444, 1'b0, 3'd0}    // t17 conflict on an invalid entry (R6)
   };

   initial begin
      model_clear();
      repeat (3) @(posedge clk);
      #2;
      // R1: state under reset
      check(!rd_valid && rd_stale, "R1 read outputs", {rd_valid, rd_stale}, 32'h1);
      check(!fetch_valid && !conflict, "R1 fetch/conflict", {fetch_valid, conflict}, 32'h0);
      rst_n = 1'b1;
      tnow  = 16'd2;

      for (int i = 0; i < 16; i++) begin
         step(VEC[i][23], VEC[i][22:20], VEC[i][19:4], VEC[i][3], VEC[i][2:0]);
         if (i == 14) check(rd_data == 16'hD003, "R9 direct wins", 32'(rd_data), 32'hD003);
         if (i == 7)  check(rd_data == 16'hA003, "R8 read old",    32'(rd_data), 32'hA003);
      end

      // R7: age at the limit versus one past it (entry 0 stamped at 2)
      step(1'b0, 3'd0, 16'h0, 1'b0, 3'd0);           // t18, lets the held write land
      tnow = 16'd22;
      step(1'b0, 3'd0, 16'h0, 1'b1, 3'd0);
      check(rd_stale == 1'b0, "R7 age equal limit", 32'(rd_stale), 32'h0);
      step(1'b0, 3'd0, 16'h0, 1'b1, 3'd0);
      check(rd_stale == 1'b1, "R7 age past limit", 32'(rd_stale), 32'h1);

      // R10: stamp near the top of time, read after the wrap
      tnow = 16'hFFF8;
      step(1'b1, 3'd5, 16'h5555, 1'b0, 3'd0);
      tnow = 16'h000C;
      step(1'b0, 3'd0, 16'h0, 1'b1, 3'd5);
      check(rd_stale == 1'b0 && rd_data == 16'h5555, "R10 wrap age 20",
            {rd_stale, 15'd0, rd_data}, 32'h5555);
      step(1'b0, 3'd0, 16'h0, 1'b1, 3'd5);
      check(rd_stale == 1'b1, "R10 wrap age 21", 32'(rd_stale), 32'h1);

      // R3 / R4 / R8 on entry 6, away from its fetch phase
      tnow = 16'd40;
      step(1'b1, 3'd6, 16'h0001, 1'b0, 3'd0);
      step(1'b1, 3'd6, 16'h0002, 1'b0, 3'd0);
      step(1'b0, 3'd0, 16'h0, 1'b1, 3'd6);
      check(rd_data == 16'h0002, "R3 latest only", 32'(rd_data), 32'h2);
      for (int k = 0; k < 2; k++) begin
         step(1'b0, 3'd0, 16'h0, 1'b1, 3'd6);
         check(rd_data == 16'h0002 && rd_valid, "R4 read again", 32'(rd_data), 32'h2);
      end
      step(1'b1, 3'd6, 16'h0003, 1'b1, 3'd6);
      check(rd_data == 16'h0002, "R8 same-cycle write", 32'(rd_data), 32'h2);

      // R1: reset in mid run clears every entry
      rst_n = 1'b0;
      #1;
      check(!rd_valid && rd_stale && !fetch_valid && !conflict, "R1 mid reset",
            {rd_valid, rd_stale, fetch_valid, conflict}, 32'h4);
      model_clear();
      @(posedge clk);
      #2;
      rst_n = 1'b1;
      step(1'b0, 3'd0, 16'h0, 1'b1, 3'd6);
      check(!rd_valid, "R1 entry cleared", 32'(rd_valid), 32'h0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule